// File: doc/BRIEF.md
# Audio Slave Start-of-Transfer Detector

This block decides when an audio serial port that runs as a clock slave may begin shifting data. It runs in the incoming bit-clock domain. It watches the word-select (WS) line and gives the shift datapath a one-cycle start strobe and a sticky running flag. Two start policies are offered. Edge policy waits for WS to move into its qualifying state. Level policy starts as soon as WS is found already in that state. Which state qualifies depends on the framing standard: WS low for the Philips framing, and WS high for MSB-justified, LSB-justified and PCM framing.

The detector works only when audio mode is selected, the enable input is high and the role is one of the two slave roles. On the first enabled bit-clock edge it captures the role, the standard and the policy, and holds them for as long as it stays enabled. From the next edge onward it tests WS. Clearing the enable input returns it to idle on the following edge, ready to arm again.

Top module: `audio_start_detect`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising clk edge), start_pulse and running are both 0.
- R2: When audio_mode is 0 or enable is 0, start_pulse and running stay 0, whatever the other inputs do.
- R3: The role encodings 2'b00 (slave transmit) and 2'b01 (slave receive) may start. The encodings 2'b10 and 2'b11 (master roles) never raise start_pulse or running.
- R4: With async_start = 0 and std_sel = 2'b00 (Philips), a fall of WS starts the transfer. WS is sampled at each rising clk edge. If WS is 1 at edge N-1 and 0 at edge N, start_pulse and running are 1 after edge N. The earliest edge N is the second enabled edge.
- R5: With async_start = 0 and std_sel = 2'b01, 2'b10 or 2'b11, a rise of WS (0 at edge N-1, 1 at edge N) starts the transfer after edge N. A fall of WS does not.
- R6: With async_start = 1, the transfer starts after the first tested edge at which WS is at the qualifying level: 0 for std_sel 2'b00, 1 for the other codes. When WS already qualifies at enable, this is the second enabled edge.
- R7: With async_start = 0, WS that already sits at the qualifying level when the block is enabled does not start a transfer. WS must first leave that level and then return.
- R8: start_pulse is high for exactly one clk cycle. running rises with it and stays 1 while the block remains enabled. Further WS activity gives no second pulse.
- R9: Clearing enable clears running and start_pulse at the next rising edge, even when a qualifying WS event falls on that same edge. After re-enabling, a fresh qualifying event is needed.
- R10: role, std_sel and async_start are captured at the first enabled edge. Changes to them while the block stays enabled have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Incoming bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| audio_mode | input | 1 | 1 selects audio framing; 0 is the other serial mode (idle) |
| enable | input | 1 | Audio port enable |
| role | input | 2 | 00 slave tx, 01 slave rx, 10 master tx, 11 master rx |
| std_sel | input | 2 | 00 Philips, 01 MSB-justified, 10 LSB-justified, 11 PCM |
| async_start | input | 1 | 0 edge start policy, 1 level start policy |
| ws | input | 1 | Word-select line, sampled on rising clk |
| start_pulse | output | 1 | One-cycle start strobe to the shifter |
| running | output | 1 | High from start until the block is disabled |

## Verification
Two functions can fall on the same edge: the disable path clearing the state, and the start decision firing on a qualifying WS transition. The bench provokes this by dropping enable and making WS fall at the same falling clk edge while the block is armed for Philips edge start. The disable must win: after the next rising edge both start_pulse and running are 0. A second case re-enables the block while WS still sits at the qualifying level in edge policy, and expects no start until WS leaves that level and returns.

// File: rtl/asd_pkg.sv
// Shared types for the audio slave start detector.
// Assumes the 2-bit standard and role codes given in the brief.
package asd_pkg;
    localparam int STD_W  = 2;
    localparam int ROLE_W = 2;

    typedef enum logic [STD_W-1:0] {
        STD_PHILIPS = 2'b00,
        STD_MSB     = 2'b01,
        STD_LSB     = 2'b10,
        STD_PCM     = 2'b11
    } std_e;

    typedef struct packed {
        logic [ROLE_W-1:0] role;
        std_e              std;
        logic              level_policy;
    } cfg_t;
endpackage

// File: rtl/asd_cfg_hold.sv
// Captures the configuration at the first enabled edge and holds it.
// Assumes active is the combined audio-mode and enable condition.
module asd_cfg_hold
    import asd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  cfg_t cfg_in,
    output logic armed,
    output cfg_t cfg_q
);
    // Arm and capture on the first active edge; drop the arm when inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cfg_q <= '0;
        end else if (!active) begin
            armed <= 1'b0;
        end else if (!armed) begin
            armed <= 1'b1;
            cfg_q <= cfg_in;
        end
    end

    // R10: the held configuration does not move while armed
    a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(armed)) |-> $stable(cfg_q));
endmodule

// File: rtl/asd_ws_qual.sv
// Samples WS and reports when it meets the held start policy.
// Assumes a registered prior sample, cleared while inactive.
module asd_ws_qual
    import asd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic armed,
    input  logic ws,
    input  std_e std,
    input  logic level_policy,
    output logic hit
);
    logic ws_prev;
    logic low_active;
    logic lvl_now;
    logic lvl_prev;

    // Keep the previous WS sample; cleared whenever the block is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) ws_prev <= 1'b0;
        else                   ws_prev <= ws;
    end

    // Map WS onto "qualifying" polarity and pick edge or level policy.
    always_comb begin
        low_active = (std == STD_PHILIPS);
        lvl_now    = ws ^ low_active;
        lvl_prev   = ws_prev ^ low_active;
        hit        = armed & (level_policy ? lvl_now : (lvl_now & ~lvl_prev));
    end
endmodule

// File: rtl/asd_start_ctl.sv
// Issues the one-cycle start strobe and keeps the running flag.
// Assumes hit is only meaningful while armed.
module asd_start_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic slave,
    input  logic hit,
    output logic start_pulse,
    output logic running
);
    logic fire;

    // A start fires once, only in a slave role and only before running.
    always_comb fire = slave & hit & ~running;

    // Register the strobe and the sticky flag; idle clears both.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            start_pulse <= 1'b0;
            running     <= 1'b0;
        end else begin
            start_pulse <= fire;
            if (fire) running <= 1'b1;
        end
    end

    // R8: the strobe never lasts two cycles
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
    // R8: running rises only together with the strobe
    a_r8_rise_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> start_pulse);
    // R8: running is sticky while active
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (running && active) |=> running);
    // R9: going idle clears everything on the next edge
    a_r9_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!running && !start_pulse));
    // R3: a strobe implies a slave role in the prior cycle
    a_r3_slave_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_pulse) |-> $past(slave));
endmodule

// File: rtl/audio_start_detect.sv
// Top of the audio slave start-of-transfer detector.
// Assumes everything runs on the incoming bit clock with a synchronous reset.
module audio_start_detect
    import asd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              audio_mode,
    input  logic              enable,
    input  logic [ROLE_W-1:0] role,
    input  logic [STD_W-1:0]  std_sel,
    input  logic              async_start,
    input  logic              ws,
    output logic              start_pulse,
    output logic              running
);
    logic active;
    logic armed;
    logic slave;
    logic hit;
    cfg_t cfg_in;
    cfg_t cfg_q;

    // Combine the gating inputs and pack the live configuration.
    always_comb begin
        active              = audio_mode & enable;
        cfg_in.role         = role;
        cfg_in.std          = std_e'(std_sel);
        cfg_in.level_policy = async_start;
        slave               = ~cfg_q.role[ROLE_W-1];
    end

    asd_cfg_hold u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .cfg_in (cfg_in),
        .armed  (armed),
        .cfg_q  (cfg_q)
    );

    asd_ws_qual u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (active),
        .armed        (armed),
        .ws           (ws),
        .std          (cfg_q.std),
        .level_policy (cfg_q.level_policy),
        .hit          (hit)
    );

    asd_start_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (active),
        .slave       (slave),
        .hit         (hit),
        .start_pulse (start_pulse),
        .running     (running)
    );

    // R2: outside audio mode or when disabled, running falls the next edge
    a_r2_idle_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !(audio_mode && enable) |=> !running);
    // R1: reset leaves both outputs low
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> (!running && !start_pulse));
endmodule

// File: tb/test_audio_start_detect.sv
module test_audio_start_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       audio_mode = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] role = 2'b00;
    logic [1:0] std_sel = 2'b00;
    logic       async_start = 1'b0;
    logic       ws = 1'b0;
    logic       start_pulse;
    logic       running;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    audio_start_detect i_audio_start_detect (
        .clk(clk), .rst_n(rst_n), .audio_mode(audio_mode), .enable(enable),
        .role(role), .std_sel(std_sel), .async_start(async_start), .ws(ws),
        .start_pulse(start_pulse), .running(running)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // Drive the setup while disabled and let the idle state settle.
    task automatic setup(input logic am, input logic [1:0] rl, input logic [1:0] sd,
                         input logic asy, input logic w);
        @(negedge clk);
        enable = 1'b0; audio_mode = am; role = rl; std_sel = sd;
        async_start = asy; ws = w;
        tick(); tick();
    endtask

    // Enable, pass the capture edge, land on the negedge before the first test edge.
    task automatic arm();
        @(negedge clk) enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        chk("R1", "pulse after reset", start_pulse, 1'b0);
        chk("R1", "running after reset", running, 1'b0);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic t_philips_edge();
        setup(1, 2'b00, 2'b00, 0, 1'b1);
        arm();
        chk("R4", "no start before ws falls", running, 1'b0);
        ws = 1'b0;
        tick();
        chk("R4", "pulse on falling ws", start_pulse, 1'b1);
        chk("R4", "running on falling ws", running, 1'b1);
        tick();
        chk("R8", "pulse lasts one cycle", start_pulse, 1'b0);
        chk("R8", "running held", running, 1'b1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk) ws = ~ws;
            tick();
            chk("R8", "no retrigger", start_pulse, 1'b0);
        end
        chk("R8", "running still held", running, 1'b1);
    endtask

    task automatic t_other_edge();
        for (int s = 1; s < 4; s++) begin
            setup(1, 2'b01, s[1:0], 0, 1'b1);
            arm();
            ws = 1'b0;
            tick();
            chk("R5", "falling ws ignored", running, 1'b0);
            @(negedge clk) ws = 1'b1;
            tick();
            chk("R5", "pulse on rising ws", start_pulse, 1'b1);
            chk("R5", "running on rising ws", running, 1'b1);
        end
    endtask

    task automatic t_level();
        setup(1, 2'b00, 2'b00, 1, 1'b0);
        @(negedge clk) enable = 1'b1;
        tick();
        chk("R6", "capture edge gives no pulse", start_pulse, 1'b0);
        tick();
        chk("R6", "philips low level starts", start_pulse, 1'b1);
        setup(1, 2'b01, 2'b11, 1, 1'b1);
        arm();
        tick();
        chk("R6", "pcm high level starts", running, 1'b1);
        setup(1, 2'b00, 2'b00, 1, 1'b1);
        arm();
        tick(); tick();
        chk("R6", "philips high level waits", running, 1'b0);
        @(negedge clk) ws = 1'b0;
        tick();
        chk("R6", "philips goes low then starts", start_pulse, 1'b1);
    endtask

    task automatic t_edge_no_level();
        setup(1, 2'b00, 2'b00, 0, 1'b0);
        arm();
        tick(); tick(); tick();
        chk("R7", "sitting low does not start", running, 1'b0);
        @(negedge clk) ws = 1'b1;
        tick();
        chk("R7", "rise gives no start", running, 1'b0);
        @(negedge clk) ws = 1'b0;
        tick();
        chk("R7", "fresh fall starts", start_pulse, 1'b1);
    endtask

    task automatic t_roles();
        for (int r = 2; r < 4; r++) begin
            setup(1, r[1:0], 2'b01, 1, 1'b1);
            arm();
            tick(); tick(); tick();
            chk("R3", "master role never starts", running, 1'b0);
        end
        setup(1, 2'b00, 2'b01, 1, 1'b1);
        arm();
        tick();
        chk("R3", "slave transmit starts", running, 1'b1);
    endtask

    task automatic t_mode();
        setup(0, 2'b00, 2'b01, 1, 1'b1);
        arm();
        tick(); tick();
        chk("R2", "non-audio mode idle", running, 1'b0);
        setup(1, 2'b00, 2'b01, 1, 1'b1);
        tick(); tick(); tick();
        chk("R2", "disabled stays idle", running, 1'b0);
        chk("R2", "disabled no pulse", start_pulse, 1'b0);
    endtask

    task automatic t_disable();
        setup(1, 2'b00, 2'b00, 0, 1'b1);
        arm();
        ws = 1'b0;
        tick();
        chk("R9", "started before disable", running, 1'b1);
        @(negedge clk) enable = 1'b0;
        tick();
        chk("R9", "disable clears running", running, 1'b0);
        arm();
        tick(); tick();
        chk("R9", "re-enable needs new event", running, 1'b0);
        // collision: disable and a qualifying fall on the same edge
        setup(1, 2'b00, 2'b00, 0, 1'b1);
        arm();
        enable = 1'b0; ws = 1'b0;
        tick();
        chk("R9", "collision no pulse", start_pulse, 1'b0);
        chk("R9", "collision not running", running, 1'b0);
    endtask

    task automatic t_cfg();
        setup(1, 2'b00, 2'b00, 0, 1'b1);
        arm();
        std_sel = 2'b01; role = 2'b10; async_start = 1'b1;
        tick(); tick();
        chk("R10", "live changes ignored", running, 1'b0);
        @(negedge clk) ws = 1'b0;
        tick();
        chk("R10", "held philips edge start", start_pulse, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_philips_edge();
        t_other_edge();
        t_level();
        t_edge_no_level();
        t_roles();
        t_mode();
        t_disable();
        t_cfg();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule